// File: doc/BRIEF.md
# Boot-Time Memory Region CRC Verifier

This block checks the integrity of a stretch of memory once, at boot. When started, it reads a contiguous window of bytes through a plain word-read port. The window begins at a given start address and covers a given byte count. The block folds each byte into a reflected CRC. It then compares the result with a stored expected digest and reports a pass or fail verdict.

One engine serves both CRC widths. A mode input picks a 32-bit or a 16-bit polynomial. A policy input can skip the check entirely, and a skipped check reports a pass.

The boot sequencer drives a start pulse. It then watches for the done pulse and reads the sticky verdict, which holds until the next done pulse. The computed digest is also brought out. The memory is modelled as a synchronous port with one cycle of read latency.

Top module: `region_crc_check`

## Requirements
- R1: After an accepted start with the bypass input low, the block reads the window through `mem_req_o`/`mem_addr_o`.
  - It makes one request per 32-bit word, at word-aligned addresses (`mem_addr_o[1:0]` is always 0).
  - Requests begin at `start_addr_i` and rise by 4 per request.
  - It takes `mem_rdata_i` one cycle after each request and consumes its bytes little-endian (bits 7:0 first).
  - Only the low-order bytes still needed are taken from the last word, so a window of L bytes costs ceil(L/4) requests.
- R2: With `mode16_i` = 0, the digest is CRC-32 with polynomial 0x04C11DB7.
  - Input bytes are processed least significant bit first, and the output is reflected (shift-right form with 0xEDB88320).
  - The register starts at 0xFFFFFFFF, the final XOR is 0, and `crc_o` shows the digest at the done pulse.
- R3: With `mode16_i` = 1, the digest is the 16-bit reflected CRC with polynomial 0x1021 (shift-right form 0x8408).
  - The register starts at 0xFFFF and the final XOR is 0.
  - `crc_o[15:0]` holds the digest and `crc_o[31:16]` is 0.
- R4: `pass_o` is 1 at the done pulse exactly when the digest equals the expected value.
  - In 32-bit mode all 32 bits of `expect_i` are compared.
  - In 16-bit mode only `expect_i[15:0]` is compared, and `expect_i[31:16]` has no effect.
- R5: A start accepted with `bypass_i` = 1 makes no memory request and keeps `busy_o` low. `done_o` and `pass_o` are both 1 in the next cycle, whatever `expect_i` is.
- R6: A length of zero makes no memory request, and the digest reported is the initial value: 0xFFFFFFFF in 32-bit mode, 0x0000FFFF in 16-bit mode. That value is compared as in R4.
- R7: Timing of the outputs:
  - `done_o` is a single-cycle pulse.
  - `busy_o` is high from the cycle after a non-bypass start until the done pulse, and is low in the done cycle.
  - `pass_o` and `crc_o` keep their values between done pulses.
- R8: A start pulse while `busy_o` is high is ignored: the running check finishes with its own result and raises only one done pulse.
- R9: A start in the same cycle as a done pulse is accepted and launches a new check.
- R10: `mem_req_o` is never high in two consecutive cycles, and is never high while `busy_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, accepted when not busy |
| bypass_i | input | 1 | Policy: 1 skips the check and reports pass |
| mode16_i | input | 1 | 1 = 16-bit CRC, 0 = 32-bit CRC |
| start_addr_i | input | 32 | First byte address of the window (word aligned) |
| byte_len_i | input | 32 | Number of bytes in the window |
| expect_i | input | 32 | First word of the stored expected digest |
| mem_req_o | output | 1 | Word read request |
| mem_addr_o | output | 32 | Word read address |
| mem_rdata_i | input | 32 | Read data, valid one cycle after the request |
| busy_o | output | 1 | Check in progress |
| done_o | output | 1 | One-cycle completion pulse |
| pass_o | output | 1 | Sticky verdict, 1 = digest matched |
| crc_o | output | 32 | Digest of the last computed check |

## Verification
The two events that can share a cycle are the completion of one check and the start of the next.

The bench provokes this by raising `start_i` in the very cycle it sees `done_o`. It judges the outcome in two ways. The finished check's verdict and digest must be the ones reported in that cycle. The new check must then run to its own correct digest with the right number of reads.

A second collision, a start arriving mid-run, is judged by a single done pulse and an unchanged result.

// File: rtl/rcc_pkg.sv
package rcc_pkg;

  // Shift-right (reflected) forms of the two generator polynomials
  localparam logic [31:0] POLY32_REFL = 32'hEDB8_8320;
  localparam logic [31:0] POLY16_REFL = 32'h0000_8408;
  localparam logic [31:0] SEED32      = 32'hFFFF_FFFF;
  localparam logic [31:0] SEED16      = 32'h0000_FFFF;

  typedef enum logic [2:0] {
    WK_IDLE,
    WK_FETCH,
    WK_WAIT,
    WK_FEED,
    WK_END
  } walk_state_t;

  function automatic logic [31:0] crc_seed(input logic narrow);
    return narrow ? SEED16 : SEED32;
  endfunction

  // One byte folded into a reflected CRC, LSB first
  function automatic logic [31:0] crc_fold_byte(input logic [31:0] cur,
                                                input logic [7:0]  data,
                                                input logic        narrow);
    logic [31:0] c;
    logic [31:0] poly;
    poly = narrow ? POLY16_REFL : POLY32_REFL;
    c = cur ^ {24'd0, data};
    for (int b = 0; b < 8; b++) begin
      if (c[0]) c = (c >> 1) ^ poly;
      else      c = c >> 1;
    end
    return c;
  endfunction

  function automatic logic digest_match(input logic [31:0] crc,
                                        input logic [31:0] expv,
                                        input logic        narrow);
    return narrow ? (crc[15:0] == expv[15:0]) : (crc == expv);
  endfunction

endpackage

// File: rtl/rcc_crc_unit.sv
module rcc_crc_unit
  import rcc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        init_i,
  input  logic        mode16_i,
  input  logic        byte_valid_i,
  input  logic [7:0]  byte_i,
  output logic        mode16_o,
  output logic [31:0] crc_o
);

  logic [31:0] crc_q;
  logic        narrow_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q    <= '0;
      narrow_q <= 1'b0;
    end else if (init_i) begin
      crc_q    <= crc_seed(mode16_i);
      narrow_q <= mode16_i;
    end else if (byte_valid_i) begin
      crc_q    <= crc_fold_byte(crc_q, byte_i, narrow_q);
    end
  end

  assign crc_o    = crc_q;
  assign mode16_o = narrow_q;

  // R3
  narrow_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    narrow_q |-> (crc_q[31:16] == 16'd0));

  // R2
  seed_after_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (init_i && !mode16_i) |=> (crc_q == SEED32));

endmodule

// File: rtl/rcc_walker.sv
module rcc_walker
  import rcc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              byte_valid_o,
  output logic [7:0]        byte_o,
  output logic              walk_done_o,
  output logic              idle_o
);

  localparam int BPW    = DATA_W / 8;
  localparam int LANE_W = (BPW > 1) ? $clog2(BPW) : 1;
  localparam int ALIGN  = $clog2(BPW);

  walk_state_t       state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  left_q;
  logic [DATA_W-1:0] word_q;
  logic [LANE_W-1:0] lane_q;
  logic [LANE_W-1:0] last_lane_q;
  logic [7:0]        lanes [BPW];

  for (genvar k = 0; k < BPW; k++) begin : g_lane
    assign lanes[k] = word_q[8*k +: 8];
  end

  logic lane_last;
  logic window_last;
  assign lane_last   = (lane_q == last_lane_q);
  assign window_last = (left_q == LEN_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= WK_IDLE;
      addr_q      <= '0;
      left_q      <= '0;
      word_q      <= '0;
      lane_q      <= '0;
      last_lane_q <= '0;
    end else begin
      unique case (state_q)
        WK_IDLE: if (go_i) begin
          addr_q  <= {base_i[ADDR_W-1:ALIGN], {ALIGN{1'b0}}};
          left_q  <= len_i;
          state_q <= (len_i == '0) ? WK_END : WK_FETCH;
        end
        WK_FETCH: state_q <= WK_WAIT;
        WK_WAIT: begin
          word_q      <= mem_rdata_i;
          lane_q      <= '0;
          last_lane_q <= (left_q >= LEN_W'(BPW)) ? LANE_W'(BPW - 1)
                                                 : LANE_W'(left_q - LEN_W'(1));
          state_q     <= WK_FEED;
        end
        WK_FEED: begin
          left_q <= left_q - LEN_W'(1);
          if (lane_last) begin
            if (window_last) begin
              state_q <= WK_END;
            end else begin
              addr_q  <= addr_q + ADDR_W'(BPW);
              state_q <= WK_FETCH;
            end
          end else begin
            lane_q <= lane_q + LANE_W'(1);
          end
        end
        WK_END:  state_q <= WK_IDLE;
        default: state_q <= WK_IDLE;
      endcase
    end
  end

  assign mem_req_o    = (state_q == WK_FETCH);
  assign mem_addr_o   = addr_q;
  assign byte_valid_o = (state_q == WK_FEED);
  assign byte_o       = lanes[lane_q];
  assign walk_done_o  = (state_q == WK_END);
  assign idle_o       = (state_q == WK_IDLE);

  // R10
  req_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o |=> !mem_req_o);

  // R6
  zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go_i && idle_o && len_i == '0) |=> (walk_done_o && !mem_req_o));

  // R1
  req_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o |-> (mem_addr_o[ALIGN-1:0] == '0));

  // R1
  byte_after_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o |=> !byte_valid_o);

endmodule

// File: rtl/region_crc_check.sv
module region_crc_check
  import rcc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              bypass_i,
  input  logic              mode16_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic [LEN_W-1:0]  byte_len_i,
  input  logic [31:0]       expect_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              pass_o,
  output logic [31:0]       crc_o
);

  logic        walk_idle;
  logic        walk_done;
  logic        byte_valid;
  logic [7:0]  byte_data;
  logic [31:0] crc_live;
  logic        narrow;
  logic        start_take;
  logic        check_go;
  logic        skip_hit;
  logic        verdict;
  logic [31:0] expect_q;
  logic        done_q;
  logic        pass_q;
  logic [31:0] crc_out_q;

  assign start_take = start_i && walk_idle;
  assign check_go   = start_take && !bypass_i;
  assign skip_hit   = start_take && bypass_i;
  assign verdict    = digest_match(crc_live, expect_q, narrow);

  rcc_walker #(
    .ADDR_W (ADDR_W),
    .LEN_W  (LEN_W),
    .DATA_W (DATA_W)
  ) u_walker (
    .clk          (clk),
    .rst_n        (rst_n),
    .go_i         (check_go),
    .base_i       (start_addr_i),
    .len_i        (byte_len_i),
    .mem_req_o    (mem_req_o),
    .mem_addr_o   (mem_addr_o),
    .mem_rdata_i  (mem_rdata_i),
    .byte_valid_o (byte_valid),
    .byte_o       (byte_data),
    .walk_done_o  (walk_done),
    .idle_o       (walk_idle)
  );

  rcc_crc_unit u_crc (
    .clk          (clk),
    .rst_n        (rst_n),
    .init_i       (check_go),
    .mode16_i     (mode16_i),
    .byte_valid_i (byte_valid),
    .byte_i       (byte_data),
    .mode16_o     (narrow),
    .crc_o        (crc_live)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      expect_q  <= '0;
      done_q    <= 1'b0;
      pass_q    <= 1'b0;
      crc_out_q <= '0;
    end else begin
      if (check_go) expect_q <= expect_i;
      if (walk_done) begin
        done_q    <= 1'b1;
        pass_q    <= verdict;
        crc_out_q <= crc_live;
      end else if (skip_hit) begin
        done_q    <= 1'b1;
        pass_q    <= 1'b1;
      end else begin
        done_q    <= 1'b0;
      end
    end
  end

  assign busy_o = !walk_idle;
  assign done_o = done_q;
  assign pass_o = pass_q;
  assign crc_o  = crc_out_q;

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R7
  done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  // R7
  verdict_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> ($stable(pass_o) && $stable(crc_o)));

  // R5
  bypass_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && bypass_i) |=> (done_o && pass_o && !busy_o));

  // R9
  restart_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && start_i && !bypass_i) |=> busy_o);

  // R10
  req_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o |-> busy_o);

  // R8
  busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i && !walk_done) |=> !done_o);

endmodule

// File: tb/region_crc_check_bench.sv
`timescale 1ns/1ps
module region_crc_check_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        bypass_i = 1'b0;
  logic        mode16_i = 1'b0;
  logic [31:0] start_addr_i = '0;
  logic [31:0] byte_len_i = '0;
  logic [31:0] expect_i = '0;
  logic        mem_req_o;
  logic [31:0] mem_addr_o;
  logic [31:0] mem_rdata_i = '0;
  logic        busy_o, done_o, pass_o;
  logic [31:0] crc_o;

  int n_vec  = 0;
  int n_fail = 0;
  int req_cnt = 0;
  int done_cnt = 0;
  logic [31:0] mem [0:63];

  always #5 clk = ~clk;

  region_crc_check u_region_crc_check (
    .clk, .rst_n, .start_i, .bypass_i, .mode16_i, .start_addr_i,
    .byte_len_i, .expect_i, .mem_req_o, .mem_addr_o, .mem_rdata_i,
    .busy_o, .done_o, .pass_o, .crc_o
  );

  always @(posedge clk) begin
    if (mem_req_o) begin
      mem_rdata_i <= mem[mem_addr_o[7:2]];
      req_cnt     <= req_cnt + 1;
    end
    if (done_o) done_cnt <= done_cnt + 1;
  end

  // Bit-serial reference: feedback bit decides the polynomial XOR
  function automatic logic [31:0] ref_crc(int sw, int len, bit m16);
    logic [31:0] c;
    logic [31:0] p;
    logic [7:0]  b;
    c = m16 ? 32'h0000FFFF : 32'hFFFFFFFF;
    p = m16 ? 32'h00008408 : 32'hEDB88320;
    for (int k = 0; k < len; k++) begin
      b = 8'(mem[sw + k / 4] >> (8 * (k % 4)));
      for (int i = 0; i < 8; i++) begin
        logic fb;
        fb = c[0] ^ b[i];
        c  = c >> 1;
        if (fb) c = c ^ p;
      end
    end
    return c;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic launch(int sw, int len, bit m16, bit byp, logic [31:0] ex);
    start_addr_i = 32'(sw * 4);
    byte_len_i   = 32'(len);
    mode16_i     = m16;
    bypass_i     = byp;
    expect_i     = ex;
    start_i      = 1'b1;
    @(negedge clk);
    start_i      = 1'b0;
  endtask

  task automatic wait_done(output bit ok);
    ok = 1'b0;
    for (int t = 0; t < 2000; t++) begin
      if (done_o) begin ok = 1'b1; break; end
      @(negedge clk);
    end
    if (!ok) begin
      n_vec++; n_fail++;
      $display("FAIL watchdog: done_o never rose actual=0 expected=1");
    end
  endtask

  // Full check of one run; includes R1/R2/R3/R4 checks
  task automatic run_check(int sw, int len, bit m16, bit corrupt);
    logic [31:0] exp_crc, ex;
    int r0;
    bit ok;
    exp_crc = ref_crc(sw, len, m16);
    ex = corrupt ? (exp_crc ^ (32'h1 << $urandom_range(0, m16 ? 15 : 31))) : exp_crc;
    if (m16) ex[31:16] = 16'($urandom);
    r0 = req_cnt;
    launch(sw, len, m16, 1'b0, ex);
    wait_done(ok);
    if (ok) begin
      chk(m16 ? "R3 crc16 digest" : "R2 crc32 digest", crc_o, exp_crc);
      chk("R4 verdict", 32'(pass_o), 32'(!corrupt));
      chk("R1 request count", 32'(req_cnt - r0), 32'((len + 3) / 4));
      chk("R7 busy low at done", 32'(busy_o), 32'd0);
    end
  endtask

  initial begin
    #2_000_000;
    n_vec++; n_fail++;
    $display("FAIL global watchdog actual=timeout expected=finish");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    bit ok;
    logic [31:0] held_crc;
    int r0, d0;
    void'($urandom(32'h5EED_0BC7));
    for (int i = 0; i < 64; i++) mem[i] = $urandom;

    repeat (3) @(negedge clk);
    // reset state
    chk("R7 reset busy", 32'(busy_o), 32'd0);
    chk("R7 reset done", 32'(done_o), 32'd0);
    chk("R7 reset pass", 32'(pass_o), 32'd0);
    chk("R10 reset req", 32'(mem_req_o), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R6: zero length, both modes
    r0 = req_cnt;
    launch(0, 0, 1'b0, 1'b0, 32'hFFFFFFFF);
    wait_done(ok);
    chk("R6 zero len crc32", crc_o, 32'hFFFFFFFF);
    chk("R6 zero len pass", 32'(pass_o), 32'd1);
    chk("R6 zero len no read", 32'(req_cnt - r0), 32'd0);
    @(negedge clk);
    launch(0, 0, 1'b1, 1'b0, 32'hABCD0000);
    wait_done(ok);
    chk("R6 zero len crc16", crc_o, 32'h0000FFFF);
    chk("R6 zero len fail16", 32'(pass_o), 32'd0);
    @(negedge clk);

    // R1: partial last word lengths, both modes
    for (int len = 1; len <= 9; len++) begin
      run_check(3, len, 1'b0, 1'b0);
      @(negedge clk);
      run_check(5, len, 1'b1, 1'b0);
      @(negedge clk);
    end

    // R4: 16-bit mode ignores upper expect bits (randomised inside run_check)
    run_check(10, 21, 1'b1, 1'b0);
    @(negedge clk);

    // R5: bypass with a wrong expect value
    r0 = req_cnt;
    held_crc = crc_o;
    launch(0, 40, 1'b0, 1'b1, 32'h0);
    chk("R5 bypass busy low", 32'(busy_o), 32'd0);
    chk("R5 bypass done", 32'(done_o), 32'd1);
    chk("R5 bypass pass", 32'(pass_o), 32'd1);
    chk("R5 bypass no read", 32'(req_cnt - r0), 32'd0);
    chk("R7 crc held over bypass", crc_o, held_crc);
    @(negedge clk);

    // R8: start while busy is ignored
    d0 = done_cnt;
    r0 = req_cnt;
    held_crc = ref_crc(2, 40, 1'b0);
    launch(2, 40, 1'b0, 1'b0, held_crc);
    repeat (4) @(negedge clk);
    launch(0, 0, 1'b1, 1'b1, 32'h0);
    wait_done(ok);
    chk("R8 crc of first run", crc_o, held_crc);
    chk("R8 pass of first run", 32'(pass_o), 32'd1);
    chk("R8 reads of first run", 32'(req_cnt - r0), 32'd10);
    repeat (12) @(negedge clk);
    chk("R8 single done", 32'(done_cnt - d0), 32'd1);

    // R9: start in the same cycle as done
    run_check(1, 13, 1'b0, 1'b1);
    r0 = req_cnt;
    held_crc = ref_crc(20, 7, 1'b1);
    launch(20, 7, 1'b1, 1'b0, held_crc);
    chk("R9 restart busy", 32'(busy_o), 32'd1);
    wait_done(ok);
    chk("R9 restart crc", crc_o, held_crc);
    chk("R9 restart pass", 32'(pass_o), 32'd1);
    chk("R9 restart reads", 32'(req_cnt - r0), 32'd2);
    @(negedge clk);

    // Random runs, mixing modes and corrupted digests (R1..R4)
    for (int n = 0; n < 40; n++) begin
      run_check(int'($urandom_range(0, 31)), int'($urandom_range(0, 64)),
                1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
      // R9: sometimes chain a restart straight off the done cycle
      if ($urandom_range(0, 1) == 0) @(negedge clk);
    end
    repeat (3) @(negedge clk);

    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

endmodule